// File: doc/BRIEF.md
# SD Card Clock Stop Controller

This block sits inside an SD host and decides, cycle by cycle, whether the card clock may be held low or must keep toggling. A divider outside the block supplies a half-period strobe. The block turns that strobe into the card clock level and a matching enable. It only opens or closes the enable while the card clock is low, so the card never sees a shortened pulse.

The command and data engines report transaction milestones as one-cycle strobes. These are: a command end with no reply expected, a command that expects a reply, the reply end, the start and last-block end of a read, the write CRC status token, and the start of card busy. The host raises a stop request whenever it wants the clock parked, for example when its buffer is empty during a write. The block honours that request only once no reply or read data is outstanding and the trailing clocks after the last transaction have been given.

Card busy may be parked. A one-shot probe then supplies a single edge so the card can let go of DAT0, unless the card has been deselected. During card initialisation, after each operating-condition poll command, the block either forces the clock to run or, in parked mode, times the gap and asks the command engine for a new poll before a programmable limit.

Top module: `sd_clk_gate_ctrl`

## Requirements
- R1: The card clock level toggles on every half-period strobe while the enable is high. The enable changes only in cycles where the card clock is low, before and after the change. While the enable is low, the card clock is low.
- R2: While reset is high: the card clock is 0, the enable is 0, the status reads parked (code 2), and the poll request is 0. With the stop request low, the enable rises in the first cycle after reset falls.
- R3: With no obligation outstanding, a stop request closes the enable at the next low phase of the clock. Dropping the request reopens the enable one cycle later.
- R4: Each of these starts a trailing count: a command end with no reply, a reply end, a last read block end, or a write CRC token. The clock then gives exactly 8 rising edges before a pending stop request can close it. Status code 1 means the trailing count is still active while the clock is enabled.
- R5: A clock that is parked is reopened, and cannot be closed, in two cases: from a reply-expecting command until its reply end, and from a read start until its last block end.
- R6: A busy strobe marks the card busy. The clock may be parked while busy, and the status reads 3. Busy clears only in the cycle after a rising edge has occurred while DAT0 is high. A DAT0 release alone leaves the status at 3.
- R7: A probe request while busy and parked opens the clock for exactly one rising edge, after which it parks again.
- R8: A deselect strobe clears busy with no clock edge, and the parked status returns to 2.
- R9: After a poll command with parked mode off, the clock runs even under a stop request until the ready strobe arrives.
- R10: With parked mode on, the clock may park during initialisation, and the status reads 4. The poll request rises once the limit count of system cycles has elapsed since the last poll command strobe, and stays high until the next poll command or the ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-period strobe from the divider |
| stop_req | input | 1 | Host asks to park the card clock |
| ev_cmd_noresp | input | 1 | End bit of a command with no reply |
| ev_cmd_resp | input | 1 | End bit of a command that expects a reply |
| ev_resp_end | input | 1 | End bit of the card reply |
| ev_rd_start | input | 1 | Read transfer started, data expected |
| ev_rd_last | input | 1 | End bit of the last read block |
| ev_wr_crc | input | 1 | Write CRC status token received |
| ev_busy | input | 1 | Card started busy on DAT0 |
| dat0 | input | 1 | Sampled DAT0 level |
| deselect | input | 1 | Card deselected strobe |
| probe_req | input | 1 | Request one probe edge while busy and parked |
| acmd41_sent | input | 1 | Operating-condition poll command issued |
| card_ready | input | 1 | Card reported ready, initialisation over |
| init_park_mode | input | 1 | 1: clock may park between polls |
| poll_limit | input | 24 | Poll interval limit in system cycles |
| sdclk | output | 1 | Card clock level |
| sdclk_en | output | 1 | Card clock enable |
| poll_req | output | 1 | Ask the command engine to reissue the poll |
| status | output | 3 | 0 run, 1 trailing, 2 parked, 3 busy parked, 4 init parked |

## Verification
The trailing rule is tried with each of the four closing milestones, plus a bare stop request that should yield zero edges. Rising edges are counted until the enable drops, so a count of 7 or 9 shows an off-by-one in the trailing counter. The reply and read cases add a long hold before the closing strobe, which separates "pending blocks the stop" from "the trailing count alone blocks it". Busy is tried in three ways: released by a probe edge, released by deselect, and with DAT0 rising while parked. The third shows whether an edge is truly required. Initialisation is tried with parked mode off, where the clock must run, and on, where the poll request must rise on exactly the limit cycle and fall on a reissued poll.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_TRAIL     = 3'd1,
        ST_STOP      = 3'd2,
        ST_BUSY_STOP = 3'd3,
        ST_INIT_POLL = 3'd4
    } clk_state_e;

    typedef struct packed {
        logic noresp_end;
        logic resp_cmd;
        logic resp_end;
        logic rd_start;
        logic rd_last;
        logic wr_crc;
    } xfer_ev_t;

    function automatic clk_state_e classify(input logic gate, input logic trail_live,
                                            input logic init_live, input logic busy);
        if (gate)           return trail_live ? ST_TRAIL : ST_RUN;
        else if (init_live) return ST_INIT_POLL;
        else if (busy)      return ST_BUSY_STOP;
        else                return ST_STOP;
    endfunction

    function automatic logic ends_transaction(input xfer_ev_t ev);
        return ev.noresp_end | ev.resp_end | ev.rd_last | ev.wr_crc;
    endfunction

endpackage

// File: rtl/sdcg_phase.sv
module sdcg_phase (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run_want,
    output logic sdclk,
    output logic gate,
    output logic rise
);
    logic toggling;

    assign toggling = tick && gate;
    assign rise     = toggling && !sdclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sdclk <= 1'b0;
            gate  <= 1'b0;
        end else begin
            if (toggling)
                sdclk <= ~sdclk;
            if (!sdclk && !toggling)
                gate <= run_want;
        end
    end

    // R1
    gate_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        (gate != $past(gate)) |-> (!$past(sdclk) && !sdclk));

    // R1
    closed_low_chk: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !sdclk);
endmodule

// File: rtl/sdcg_trail.sv
module sdcg_trail
    import sdcg_pkg::*;
#(
    parameter int TRAIL_CLKS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  xfer_ev_t ev,
    input  logic     rise,
    output logic     trail_live,
    output logic     resp_pend,
    output logic     rd_pend
);
    localparam int TW = $clog2(TRAIL_CLKS + 1);

    logic [TW-1:0] cnt;
    logic          load;

    assign load       = ends_transaction(ev);
    assign trail_live = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= TW'(TRAIL_CLKS);
        else if (rise && trail_live)
            cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_pend <= 1'b0;
            rd_pend   <= 1'b0;
        end else begin
            if (ev.resp_end)      resp_pend <= 1'b0;
            else if (ev.resp_cmd) resp_pend <= 1'b1;
            if (ev.rd_last)       rd_pend   <= 1'b0;
            else if (ev.rd_start) rd_pend   <= 1'b1;
        end
    end

    // R4
    trail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trail_live && !rise && !load) |=> $stable(cnt));
endmodule

// File: rtl/sdcg_busy.sv
module sdcg_busy (
    input  logic clk,
    input  logic rst,
    input  logic busy_ev,
    input  logic dat0,
    input  logic deselect,
    input  logic probe_req,
    input  logic gate,
    input  logic rise,
    output logic busy,
    output logic probe_active
);
    logic edge_seen;

    always_ff @(posedge clk) begin
        if (rst)
            edge_seen <= 1'b0;
        else if (busy_ev || !dat0)
            edge_seen <= 1'b0;
        else if (rise)
            edge_seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (deselect)
            busy <= 1'b0;
        else if (busy_ev)
            busy <= 1'b1;
        else if (edge_seen && dat0)
            busy <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            probe_active <= 1'b0;
        else if (rise || !busy)
            probe_active <= 1'b0;
        else if (probe_req && !gate)
            probe_active <= 1'b1;
    end

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(deselect) || $past(dat0)));
endmodule

// File: rtl/sdcg_initpoll.sv
module sdcg_initpoll #(
    parameter int POLL_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acmd41_sent,
    input  logic              card_ready,
    input  logic              park_mode,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              init_live,
    output logic              hold_clk,
    output logic              poll_req
);
    logic [POLL_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            init_live <= 1'b0;
        else if (card_ready)
            init_live <= 1'b0;
        else if (acmd41_sent)
            init_live <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (acmd41_sent)
            cnt <= '0;
        else if (init_live && cnt != poll_limit)
            cnt <= cnt + 1'b1;
    end

    assign hold_clk = init_live && !park_mode;
    assign poll_req = init_live && park_mode && (cnt == poll_limit);

    // R10
    poll_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acmd41_sent && poll_limit != '0) |=> !poll_req);
endmodule

// File: rtl/sd_clk_gate_ctrl.sv
module sd_clk_gate_ctrl
    import sdcg_pkg::*;
#(
    parameter int TRAIL_CLKS = 8,
    parameter int POLL_W     = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              stop_req,
    input  logic              ev_cmd_noresp,
    input  logic              ev_cmd_resp,
    input  logic              ev_resp_end,
    input  logic              ev_rd_start,
    input  logic              ev_rd_last,
    input  logic              ev_wr_crc,
    input  logic              ev_busy,
    input  logic              dat0,
    input  logic              deselect,
    input  logic              probe_req,
    input  logic              acmd41_sent,
    input  logic              card_ready,
    input  logic              init_park_mode,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              sdclk,
    output logic              sdclk_en,
    output logic              poll_req,
    output logic [2:0]        status
);
    xfer_ev_t   ev;
    logic       gate, rise, run_want, must_run;
    logic       trail_live, resp_pend, rd_pend;
    logic       busy, probe_active;
    logic       init_live, hold_clk;
    clk_state_e st;

    assign ev = '{noresp_end: ev_cmd_noresp, resp_cmd: ev_cmd_resp, resp_end: ev_resp_end,
                  rd_start: ev_rd_start, rd_last: ev_rd_last, wr_crc: ev_wr_crc};

    assign must_run = resp_pend | rd_pend | trail_live | probe_active | hold_clk;
    assign run_want = !stop_req | must_run;

    sdcg_phase u_phase (
        .clk(clk), .rst(rst), .tick(tick), .run_want(run_want),
        .sdclk(sdclk), .gate(gate), .rise(rise)
    );

    sdcg_trail #(.TRAIL_CLKS(TRAIL_CLKS)) u_trail (
        .clk(clk), .rst(rst), .ev(ev), .rise(rise),
        .trail_live(trail_live), .resp_pend(resp_pend), .rd_pend(rd_pend)
    );

    sdcg_busy u_busy (
        .clk(clk), .rst(rst), .busy_ev(ev_busy), .dat0(dat0), .deselect(deselect),
        .probe_req(probe_req), .gate(gate), .rise(rise),
        .busy(busy), .probe_active(probe_active)
    );

    sdcg_initpoll #(.POLL_W(POLL_W)) u_init (
        .clk(clk), .rst(rst), .acmd41_sent(acmd41_sent), .card_ready(card_ready),
        .park_mode(init_park_mode), .poll_limit(poll_limit),
        .init_live(init_live), .hold_clk(hold_clk), .poll_req(poll_req)
    );

    assign st       = classify(gate, trail_live, init_live, busy);
    assign status   = st;
    assign sdclk_en = gate;

    // R5
    obligation_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && must_run) |=> gate);
endmodule

// File: tb/sd_clk_gate_ctrl_test.sv
module sd_clk_gate_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 0, stop_req = 0;
    logic        ev_cmd_noresp = 0, ev_cmd_resp = 0, ev_resp_end = 0;
    logic        ev_rd_start = 0, ev_rd_last = 0, ev_wr_crc = 0, ev_busy = 0;
    logic        dat0 = 1, deselect = 0, probe_req = 0;
    logic        acmd41_sent = 0, card_ready = 0, init_park_mode = 0;
    logic [23:0] poll_limit = 24'd20;
    logic        sdclk, sdclk_en, poll_req;
    logic [2:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sd_clk_gate_ctrl uut (
        .clk(clk), .rst(rst), .tick(tick), .stop_req(stop_req),
        .ev_cmd_noresp(ev_cmd_noresp), .ev_cmd_resp(ev_cmd_resp), .ev_resp_end(ev_resp_end),
        .ev_rd_start(ev_rd_start), .ev_rd_last(ev_rd_last), .ev_wr_crc(ev_wr_crc),
        .ev_busy(ev_busy), .dat0(dat0), .deselect(deselect), .probe_req(probe_req),
        .acmd41_sent(acmd41_sent), .card_ready(card_ready), .init_park_mode(init_park_mode),
        .poll_limit(poll_limit), .sdclk(sdclk), .sdclk_en(sdclk_en),
        .poll_req(poll_req), .status(status)
    );

    // trailing table: kind[11:8] hold halves[7:4] expected rises[3:0]
    // kind 0 bare stop, 1 no-reply cmd, 2 reply, 3 read, 4 write CRC
    localparam logic [11:0] TVEC [0:4] = '{
        12'h0_0_0, 12'h1_0_8, 12'h2_A_8, 12'h3_C_8, 12'h4_0_8
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic half();
        tick = 1'b1; step();
        tick = 1'b0; step();
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input int which);
        case (which)
            1:  ev_cmd_noresp = 1'b1;
            2:  ev_cmd_resp   = 1'b1;
            3:  ev_resp_end   = 1'b1;
            4:  ev_rd_start   = 1'b1;
            5:  ev_rd_last    = 1'b1;
            6:  ev_wr_crc     = 1'b1;
            7:  ev_busy       = 1'b1;
            8:  deselect      = 1'b1;
            9:  probe_req     = 1'b1;
            10: acmd41_sent   = 1'b1;
            11: card_ready    = 1'b1;
            default: ;
        endcase
        step();
        {ev_cmd_noresp, ev_cmd_resp, ev_resp_end, ev_rd_start, ev_rd_last, ev_wr_crc} = '0;
        {ev_busy, deselect, probe_req, acmd41_sent, card_ready} = '0;
        step();
    endtask

    task automatic park();
        stop_req = 1'b1;
        for (int i = 0; i < 6 && (sdclk_en || sdclk); i++) half();
    endtask

    task automatic count_rises(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            logic prev;
            prev = sdclk;
            half();
            if (!prev && sdclk) n++;
            if (!sdclk_en && !sdclk) break;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) step();
        // R2 reset values
        chk(sdclk == 0 && sdclk_en == 0, "R2 reset clock", {sdclk, sdclk_en}, 0);
        chk(status == 3'd2 && poll_req == 0, "R2 reset status", status, 2);
        rst = 1'b0;
        step();
        chk(sdclk_en == 1, "R2 enable after reset", sdclk_en, 1);

        // R1 toggling on each strobe
        for (int i = 0; i < 4; i++) begin
            logic prev;
            prev = sdclk;
            half();
            chk(sdclk == !prev, "R1 toggle", sdclk, !prev);
        end
        half();
        stop_req = 1'b1;
        step();
        chk(sdclk_en == 1 && sdclk == 1, "R1 enable held in high phase", sdclk_en, 1);
        half();
        chk(sdclk_en == 0 && sdclk == 0, "R3 parked at low phase", sdclk_en, 0);
        stop_req = 1'b0;
        step();
        chk(sdclk_en == 1, "R3 reopen", sdclk_en, 1);
        park();
        chk(sdclk_en == 0, "R3 parked again", sdclk_en, 0);

        // R4 R5 trailing table
        for (int v = 0; v < 5; v++) begin
            int kind, hold, exp;
            bit stayed;
            kind = int'(TVEC[v][11:8]);
            hold = int'(TVEC[v][7:4]);
            exp  = int'(TVEC[v][3:0]);
            stayed = 1'b1;
            if (kind == 2 || kind == 3) begin
                fire(kind == 2 ? 2 : 4);
                for (int h = 0; h < hold; h++) begin
                    half();
                    if (!sdclk_en) stayed = 1'b0;
                end
                chk(stayed, "R5 pending blocks stop", int'(stayed), 1);
                fire(kind == 2 ? 3 : 5);
            end else if (kind == 1) begin
                fire(1);
            end else if (kind == 4) begin
                fire(6);
            end
            if (exp != 0) begin
                half();
                chk(status == 3'd1, "R4 trailing status", status, 1);
                count_rises(40, n);
                n++;
            end else begin
                count_rises(40, n);
            end
            chk(n == exp, "R4 trailing edge count", n, exp);
            chk(sdclk_en == 0 && sdclk == 0, "R4 parked after trailing", sdclk_en, 0);
        end

        // R6 R7 busy park and probe
        dat0 = 1'b0;
        fire(7);
        chk(status == 3'd3 && sdclk_en == 0, "R6 busy parked", status, 3);
        dat0 = 1'b1;
        repeat (3) half();
        chk(status == 3'd3 && sdclk == 0, "R6 busy kept without edge", status, 3);
        fire(9);
        count_rises(6, n);
        repeat (2) half();
        chk(n == 1, "R7 single probe edge", n, 1);
        chk(sdclk_en == 0, "R7 parked after probe", sdclk_en, 0);
        chk(status == 3'd2, "R6 busy released after edge", status, 2);

        // R8 deselect clears busy
        dat0 = 1'b0;
        fire(7);
        chk(status == 3'd3, "R8 busy set", status, 3);
        fire(8);
        chk(status == 3'd2 && sdclk == 0, "R8 deselect clears busy", status, 2);
        dat0 = 1'b1;

        // R9 forced run during init
        init_park_mode = 1'b0;
        fire(10);
        count_rises(10, n);
        chk(sdclk_en == 1 && n == 5, "R9 clock runs in init", n, 5);
        chk(status == 3'd0, "R9 run status", status, 0);
        fire(11);
        half(); half();
        chk(sdclk_en == 0 && status == 3'd2, "R9 parks after ready", status, 2);

        // R10 parked init with poll timer
        init_park_mode = 1'b1;
        poll_limit = 24'd20;
        fire(10);
        chk(status == 3'd4 && sdclk_en == 0, "R10 init parked status", status, 4);
        repeat (18) step();
        chk(poll_req == 0, "R10 poll not early", poll_req, 0);
        step();
        chk(poll_req == 1, "R10 poll at limit", poll_req, 1);
        repeat (5) step();
        chk(poll_req == 1, "R10 poll held", poll_req, 1);
        fire(10);
        chk(poll_req == 0, "R10 poll cleared by reissue", poll_req, 0);
        fire(11);
        chk(poll_req == 0 && status == 3'd2, "R10 ready ends window", status, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule